// File: doc/BRIEF.md
# Printer-Port Nibble Register Interface

This block is the device-side decoder for a network adapter that hangs off a host printer port. The host writes one byte per strobe on an 8-bit data path. The top three bits of each byte carry a command. Bit 4 picks the upper or lower half of a byte. The low four bits carry a register number or a data nibble. The block turns this byte stream into accesses to a sixteen-entry register file and a byte-wide packet buffer, and returns read data four bits at a time on status lines.

A register is written through a short sequence. The host presents the address, then the data, then lowers the write bit; the data lands only at that last step. Reads select a register and leave its nibble on the status lines until the next command. Register 14 is a window onto the packet buffer. Writes to it set the buffer address. Reads of it return the byte at the current address and step the address forward. Bulk writes stream bytes into the buffer as low/high nibble pairs, and the address steps forward after each byte.

Top module: `nibble_port_if`

## Requirements
- R1: After reset the status lines read 0, every plain register reads 0 and the buffer address is 0.
- R2: A strobed byte equal to the previous strobed byte is discarded and has no effect.
- R3: A byte with bits 7:5 = 010 holds a write address, with bits 3:0 giving the register and bit 4 selecting the high nibble. The first later byte with bits 7:5 = 000 writes its bits 3:0 into that half of the register. Other 010 bytes in between are ignored.
- R4: After such a commit, further bytes with bits 7:5 = 000 have no effect until another command byte arrives.
- R5: A byte with bits 7:5 = 110 selects register bits 3:0 for reading, with bit 4 set selecting the high nibble. From the second clock after its strobe, status bits 6:3 carry that nibble and status bits 7 and 2:0 are 0.
- R6: A byte with bits 7:5 = 111 ends any command. Status returns to 0, and a pending bulk low nibble is dropped.
- R7: Outside a command, a byte 000x_dddd with bit 4 = 0 holds a low nibble. The next such byte with bit 4 = 1 writes {its nibble, held nibble} to the buffer at the current address, and the address then increases by one. A 16-bit word goes as four nibbles, least significant first.
- R8: A bulk high nibble with no held low nibble is ignored.
- R9: Reading register 14 returns a nibble of the buffer byte at the current address. Leaving a high-nibble read of register 14 (the next accepted command byte) increases the address by one.
- R10: Writing register 14 loads the low nibble or the high nibble of the buffer address. Address bits beyond the parameter width are dropped.
- R11: The buffer address wraps from 2^ADDR_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostStrobe | input | 1 | One-cycle pulse marking a new host byte |
| hostData | input | 8 | Byte written by the host |
| statusOut | output | 8 | Status lines; read nibble on bits 6:3 |

## Verification
The bench builds the block with ADDR_W = 4, so the buffer has only sixteen bytes. With that width, the address wrap of R11 and the truncation of the high address nibble of R10 are reached in a few dozen host bytes. MAR_IDX stays at 14, so the buffer window is at the register number the host expects. Readback of the buffer always goes through the status lines, with the address stepped by high-nibble reads.

// File: rtl/nibble_port_pkg.sv
package nibble_port_pkg;
  localparam int NIB_W    = 4;
  localparam int NUM_REGS = 1 << NIB_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WADDR,
    ST_WDONE,
    ST_READ
  } portState_t;

  // control -> datapath strobes and read selection
  typedef struct packed {
    logic             regWr;
    logic             bufLo;
    logic             bufWr;
    logic             addrInc;
    logic [NIB_W-1:0] nib;
    logic [NIB_W-1:0] wrIdx;
    logic             wrHi;
    logic             rdActive;
    logic [NIB_W-1:0] rdIdx;
    logic             rdHi;
  } dpStrobes_t;
endpackage

// File: rtl/nibble_port_ctrl.sv
module nibble_port_ctrl
  import nibble_port_pkg::*;
#(
  parameter int MAR_IDX = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostStrobe,
  input  logic [7:0] hostData,
  output dpStrobes_t stb
);
  portState_t       state, stateN;
  logic [NIB_W-1:0] wrIdx, wrIdxN, rdIdx, rdIdxN;
  logic             wrHi, wrHiN, rdHi, rdHiN, pendLo, pendLoN;
  logic [7:0]       lastByte;
  logic             lastValid;

  logic       dup, take, hiBit, leaveMarHi;
  logic [2:0] cmd;
  logic [NIB_W-1:0] nib;

  assign dup        = lastValid && (hostData == lastByte);
  assign take       = hostStrobe && !dup;
  assign cmd        = hostData[7:5];
  assign hiBit      = hostData[4];
  assign nib        = hostData[3:0];
  assign leaveMarHi = (state == ST_READ) && (rdIdx == 4'(MAR_IDX)) && rdHi;

  always_comb begin
    stateN       = state;
    wrIdxN       = wrIdx;
    wrHiN        = wrHi;
    rdIdxN       = rdIdx;
    rdHiN        = rdHi;
    pendLoN      = pendLo;
    stb          = '0;
    stb.nib      = nib;
    stb.wrIdx    = wrIdx;
    stb.wrHi     = wrHi;
    stb.rdActive = (state == ST_READ);
    stb.rdIdx    = rdIdx;
    stb.rdHi     = rdHi;
    if (take) begin
      case (cmd)
        3'b111: begin
          stb.addrInc = leaveMarHi;
          stateN      = ST_IDLE;
          pendLoN     = 1'b0;
        end
        3'b010: begin
          pendLoN = 1'b0;
          if (state != ST_WADDR) begin
            stb.addrInc = leaveMarHi;
            wrIdxN      = nib;
            wrHiN       = hiBit;
            stateN      = ST_WADDR;
          end
        end
        3'b110: begin
          stb.addrInc = leaveMarHi;
          rdIdxN      = nib;
          rdHiN       = hiBit;
          stateN      = ST_READ;
          pendLoN     = 1'b0;
        end
        3'b000: begin
          if (state == ST_WADDR) begin
            stb.regWr = 1'b1;
            stateN    = ST_WDONE;
          end else if (state == ST_IDLE) begin
            if (!hiBit) begin
              stb.bufLo = 1'b1;
              pendLoN   = 1'b1;
            end else if (pendLo) begin
              stb.bufWr = 1'b1;
              pendLoN   = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wrIdx     <= '0;
      wrHi      <= 1'b0;
      rdIdx     <= '0;
      rdHi      <= 1'b0;
      pendLo    <= 1'b0;
      lastByte  <= '0;
      lastValid <= 1'b0;
    end else begin
      state  <= stateN;
      wrIdx  <= wrIdxN;
      wrHi   <= wrHiN;
      rdIdx  <= rdIdxN;
      rdHi   <= rdHiN;
      pendLo <= pendLoN;
      if (hostStrobe) begin
        lastByte  <= hostData;
        lastValid <= 1'b1;
      end
    end
  end

  // R8: a buffer byte is only ever written on top of a held low nibble
  a_r8_hi_needs_lo: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufWr |-> pendLo);
  // R2: a repeated byte raises no strobe
  a_r2_dup_inert: assert property (@(posedge clk) disable iff (!rstN)
    (hostStrobe && lastValid && hostData == lastByte)
      |-> !(stb.regWr || stb.bufWr || stb.bufLo || stb.addrInc));
  // R4: after a commit no second commit until a new address
  a_r4_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    stb.regWr |=> (state == ST_WDONE));
endmodule

// File: rtl/nibble_port_dp.sv
module nibble_port_dp
  import nibble_port_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int MAR_IDX = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobes_t stb,
  output logic [7:0] statusOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        regQ [NUM_REGS];
  logic [7:0]        bufMem [DEPTH];
  logic [ADDR_W-1:0] addr;
  logic [NIB_W-1:0]  loNib;
  logic [7:0]        addrWide, addrSet, rdByte;
  logic [NIB_W-1:0]  rdNib;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == MAR_IDX) begin : g_window
      assign regQ[g] = '0;
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN) regQ[g] <= '0;
        else if (stb.regWr && stb.wrIdx == 4'(g)) begin
          if (stb.wrHi) regQ[g][7:4] <= stb.nib;
          else          regQ[g][3:0] <= stb.nib;
        end
      end
    end
  end

  assign addrWide = 8'(addr);
  always_comb begin
    addrSet = addrWide;
    if (stb.wrHi) addrSet[7:4] = stb.nib;
    else          addrSet[3:0] = stb.nib;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr  <= '0;
      loNib <= '0;
    end else begin
      if (stb.bufLo) loNib <= stb.nib;
      if (stb.regWr && stb.wrIdx == 4'(MAR_IDX)) addr <= addrSet[ADDR_W-1:0];
      else if (stb.bufWr || stb.addrInc)         addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.bufWr) bufMem[addr] <= {stb.nib, loNib};
  end

  assign rdByte = (stb.rdIdx == 4'(MAR_IDX)) ? bufMem[addr] : regQ[stb.rdIdx];
  assign rdNib  = stb.rdHi ? rdByte[7:4] : rdByte[3:0];

  always_ff @(posedge clk) begin
    if (!rstN)             statusOut <= '0;
    else if (stb.rdActive) statusOut <= {1'b0, rdNib, 3'b000};
    else                   statusOut <= '0;
  end

  // R7/R11: every buffer step moves the address by exactly one, wrapping
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.bufWr || stb.addrInc) && !stb.regWr) |=> addr == ADDR_W'($past(addr) + 1'b1));
  // R6: with no read selected the status lines fall to zero
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdActive |=> statusOut == 8'h00);
  // R10: a window write loads the address nibble
  a_r10_addr_load: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWr && stb.wrIdx == 4'(MAR_IDX) && !stb.wrHi) |=> addr[3:0] == $past(stb.nib));
endmodule

// File: rtl/nibble_port_if.sv
module nibble_port_if
  import nibble_port_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int MAR_IDX = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostStrobe,
  input  logic [7:0] hostData,
  output logic [7:0] statusOut
);
  dpStrobes_t stb;

  nibble_port_ctrl #(.MAR_IDX(MAR_IDX)) i_ctrl (
    .clk(clk), .rstN(rstN), .hostStrobe(hostStrobe), .hostData(hostData), .stb(stb)
  );

  nibble_port_dp #(.ADDR_W(ADDR_W), .MAR_IDX(MAR_IDX)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .statusOut(statusOut)
  );
endmodule

// File: tb/test_nibble_port_if.sv
module test_nibble_port_if;
  logic       clk = 1'b0;
  logic       rstN;
  logic       hostStrobe;
  logic [7:0] hostData;
  logic [7:0] statusOut;
  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;

  nibble_port_if #(.ADDR_W(4), .MAR_IDX(14)) i_nibble_port_if (
    .clk(clk), .rstN(rstN), .hostStrobe(hostStrobe), .hostData(hostData), .statusOut(statusOut)
  );

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    hostData   = b;
    hostStrobe = 1'b1;
    @(negedge clk);
    hostStrobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic readNib(input int r, input int hi, output int nib);
    sendByte(8'hE0 | 8'(r));
    sendByte(8'hC0 | 8'(hi << 4) | 8'(r));
    nib = int'(statusOut[6:3]);
    sendByte(8'hE0 | 8'(r));
  endtask

  task automatic writeNib(input int r, input int hi, input int v);
    sendByte(8'hE0 | 8'(r));
    sendByte(8'h40 | 8'(hi << 4) | 8'(r));
    sendByte(8'h40 | 8'(hi << 4) | 8'(r));
    sendByte(8'h40 | 8'(v));
    sendByte(8'(hi << 4) | 8'(v));
    sendByte(8'(hi << 4) | 8'(v));
    sendByte(8'hE0 | 8'(v));
  endtask

  task automatic setAddr(input int a);
    writeNib(14, 0, a & 15);
    writeNib(14, 1, (a >> 4) & 15);
  endtask

  task automatic bulkByte(input logic [7:0] b);
    sendByte({4'h0, b[3:0]});
    sendByte({4'h1, b[7:4]});
  endtask

  task automatic readBuf(input string req, input logic [7:0] exp);
    int lo, hi;
    sendByte(8'hCE);
    lo = int'(statusOut[6:3]);
    sendByte(8'hDE);
    hi = int'(statusOut[6:3]);
    check(req, (hi << 4) | lo, int'(exp));
  endtask

  task automatic t_reset;
    int n;
    check("R1 status after reset", int'(statusOut), 0);
    readNib(9, 0, n); check("R1 reg9 low", n, 0);
    readNib(9, 1, n); check("R1 reg9 high", n, 0);
    sendByte(8'hEE); readBuf("R1 address 0 after reset (R9)", 8'hxx);
  endtask

  task automatic t_regWrite;
    int n;
    writeNib(3, 0, 4'hA);
    writeNib(3, 1, 4'h5);
    readNib(3, 0, n); check("R3 reg3 low", n, 4'hA);
    readNib(3, 1, n); check("R3 reg3 high", n, 4'h5);
    writeNib(11, 1, 4'hC);
    readNib(11, 1, n); check("R3 reg11 high", n, 4'hC);
    readNib(11, 0, n); check("R3 reg11 low untouched", n, 0);
    sendByte(8'hE3); sendByte(8'hD3);
    check("R5 status framing", int'(statusOut), 8'h5 << 3);
    sendByte(8'hE3);
    check("R6 status cleared by end", int'(statusOut), 0);
  endtask

  task automatic t_afterCommit;
    int n;
    sendByte(8'hE6); sendByte(8'h46); sendByte(8'h46); sendByte(8'h4A);
    sendByte(8'h0A); sendByte(8'h0A); sendByte(8'h03); sendByte(8'hE0);
    readNib(6, 0, n); check("R4 late nibble ignored", n, 4'hA);
  endtask

  task automatic t_bulk;
    setAddr(5);
    sendByte(8'hE0);
    sendByte(8'h1F);
    bulkByte(8'h66);
    sendByte(8'h05); sendByte(8'hE0); sendByte(8'h17);
    bulkByte(8'h88);
    sendByte(8'h03); sendByte(8'h12); sendByte(8'h05); sendByte(8'h14);
    setAddr(5);
    sendByte(8'hEE);
    readBuf("R8 lone high ignored", 8'h66);
    readBuf("R6 pending low dropped", 8'h88);
    readBuf("R7 word low byte", 8'h23);
    readBuf("R7 word high byte", 8'h45);
    sendByte(8'hEE);
  endtask

  task automatic t_dupRead;
    int lo;
    setAddr(5);
    sendByte(8'hEE); sendByte(8'hCE); sendByte(8'hDE); sendByte(8'hDE);
    sendByte(8'hCE);
    lo = int'(statusOut[6:3]);
    check("R2 repeated high read steps once", lo, 8);
    sendByte(8'hEE);
  endtask

  task automatic t_wrap;
    setAddr(8'hFF);
    sendByte(8'hE0);
    bulkByte(8'h9C);
    bulkByte(8'h7D);
    setAddr(15);
    sendByte(8'hEE);
    readBuf("R10 high bits dropped", 8'h9C);
    readBuf("R11 wrap to 0", 8'h7D);
    sendByte(8'hEE);
  endtask

  initial begin
    rstN = 1'b0; hostStrobe = 1'b0; hostData = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status idle", int'(statusOut), 0);
    begin
      int n;
      readNib(0, 0, n); check("R1 reg0 low", n, 0);
    end
    t_regWrite();
    t_afterCommit();
    t_bulk();
    t_dupRead();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule